// File: doc/BRIEF.md
# PTP Time-of-Day Counter with Software Steering

This block keeps the local precision-time-protocol clock as a 48-bit seconds count and a 30-bit nanoseconds count. Each cycle of the 125 MHz system clock adds the per-tick increment to the time. The increment has an integer part, 8 ns after reset, and a 32-bit binary fraction of a nanosecond. The fraction is summed in an accumulator, and each overflow of that accumulator adds one extra nanosecond. Software steers the clock in three ways: it can load an absolute time, add or subtract a signed offset once, or replace the increment to trim the rate.

A small steering state machine registers each strobe together with its operands. In the following cycle it applies the requested operation. It has three states. `ST_RUN` is the normal tick. `ST_LOAD` loads the captured absolute time. `ST_SHIFT` ticks and applies the captured offset in the same cycle. On every clock the next state is chosen from the strobes alone, whatever the current state is:
- `set_stb` leads to `ST_LOAD`.
- Otherwise `adj_stb` leads to `ST_SHIFT`.
- Otherwise the machine returns to `ST_RUN`.

One normalizer handles all three states. It folds any nanoseconds result back into the range 0 to 999,999,999 and moves up to two seconds of carry or borrow into the seconds field.

Top module: `ptp_tod_clock`

## Requirements
- R1: While reset is held, and in the cycle it is released, `tod_sec` and `tod_ns` read 0 and the increment is 8 ns with a zero fraction.
- R2: At every clock edge with no steering operation pending, the time advances by the integer increment plus any carry out of the fraction accumulator.
- R3: The 32-bit fraction accumulator adds `inc_frac` (units of 2^-32 ns) on every edge, and each wrap past 2^32 adds 1 ns on that edge. The accumulator is cleared on the edge that applies an absolute load.
- R4: When a nanoseconds result reaches 1,000,000,000, that amount is taken off and seconds increase by one. `tod_ns` never shows a value of 1,000,000,000 or more.
- R5: A `set_stb` sampled at edge k makes the outputs equal `set_sec`/`set_ns` after edge k+1, and normal ticking resumes at edge k+2. Edge k itself is an ordinary tick. A written `set_ns` of 1,000,000,000 or more is reduced by that amount, with one second carried.
- R6: An `adj_stb` with `adj_neg`=0 sampled at edge k makes edge k+1 add the normal step plus `adj_sec` seconds and `adj_ns` nanoseconds. Up to two seconds of carry are propagated.
- R7: With `adj_neg`=1 the offset is subtracted instead, and up to two seconds of borrow are taken from the seconds field.
- R8: When `set_stb` and `adj_stb` are sampled at the same edge, only the absolute load takes effect and the offset is discarded.
- R9: An `inc_stb` sampled at edge k stores `inc_ns`/`inc_frac`. The tick at edge k still uses the previous increment, and the new one applies from edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_stb | input | 1 | Absolute time load request |
| set_sec | input | 48 | Seconds value to load |
| set_ns | input | 30 | Nanoseconds value to load |
| adj_stb | input | 1 | Offset adjust request |
| adj_neg | input | 1 | 1 = subtract offset, 0 = add offset |
| adj_sec | input | 48 | Offset magnitude, seconds |
| adj_ns | input | 30 | Offset magnitude, nanoseconds |
| inc_stb | input | 1 | Increment update request |
| inc_ns | input | 6 | Integer nanoseconds per tick |
| inc_frac | input | 32 | Fractional nanoseconds per tick, units of 2^-32 ns |
| tod_sec | output | 48 | Current time, seconds |
| tod_ns | output | 30 | Current time, nanoseconds |

## Verification
Free running after reset confirms the plain 8 ns step. A load placed just below a second boundary separates the rollover path from ordinary ticking. Positive and negative offsets are tried at sizes that cross zero, one and two second boundaries, which separates the single and double carry and borrow branches of the normalizer. A load with an oversized nanoseconds value checks the same normalizer on the load path. Coincident load and adjust strobes expose the priority between them. Runs with half-nanosecond and quarter-nanosecond fractions, each started by a load, show whether carries land on the right edges and whether the load resets the accumulator phase. Changing the increment shows on which edge the new rate takes over.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

    localparam longint NS_PER_SEC = 64'd1_000_000_000;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } steer_state_e;

endpackage

// File: rtl/tod_rate_accum.sv
module tod_rate_accum #(
    parameter int INC_W   = 6,
    parameter int FRAC_W  = 32,
    parameter int RST_INC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_stb,
    input  logic [INC_W-1:0]  inc_ns,
    input  logic [FRAC_W-1:0] inc_frac,
    input  logic              restart,
    output logic [INC_W:0]    step_ns
);

    logic [INC_W-1:0]  inc_ns_q;
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_sum;
    logic              carry;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_ns_q <= INC_W'(RST_INC);
            frac_q   <= '0;
        end else if (inc_stb) begin
            inc_ns_q <= inc_ns;
            frac_q   <= inc_frac;
        end
    end

    always_comb begin
        {carry, acc_sum} = {1'b0, acc_q} + {1'b0, frac_q};
        step_ns          = {1'b0, inc_ns_q} + {{INC_W{1'b0}}, carry};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_sum;
        end
    end

    // R9: a stored increment is the value presented with its strobe
    p_inc_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inc_stb |=> (inc_ns_q == $past(inc_ns)) && (frac_q == $past(inc_frac)));

    // R3: the accumulator starts from zero after a load
    p_restart_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (acc_q == '0));

    // R3: outside a load the accumulator sums the fraction, modulo 2^FRAC_W
    p_frac_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (acc_q == FRAC_W'($past(acc_q) + $past(frac_q))));

endmodule

// File: rtl/tod_steer_fsm.sv
module tod_steer_fsm
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic [SEC_W-1:0] set_sec,
    input  logic [NS_W-1:0]  set_ns,
    input  logic             adj_stb,
    input  logic             adj_neg,
    input  logic [SEC_W-1:0] adj_sec,
    input  logic [NS_W-1:0]  adj_ns,
    output steer_state_e     state,
    output logic [SEC_W-1:0] ld_sec,
    output logic [NS_W-1:0]  ld_ns,
    output logic             off_neg,
    output logic [SEC_W-1:0] off_sec,
    output logic [NS_W-1:0]  off_ns
);

    steer_state_e state_q;
    steer_state_e state_d;

    // Next state: a load request outranks an offset request
    always_comb begin
        if (set_stb) begin
            state_d = ST_LOAD;
        end else if (adj_stb) begin
            state_d = ST_SHIFT;
        end else begin
            state_d = ST_RUN;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Operand capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_sec  <= '0;
            ld_ns   <= '0;
            off_neg <= 1'b0;
            off_sec <= '0;
            off_ns  <= '0;
        end else begin
            if (set_stb) begin
                ld_sec <= set_sec;
                ld_ns  <= set_ns;
            end
            if (adj_stb) begin
                off_neg <= adj_neg;
                off_sec <= adj_sec;
                off_ns  <= adj_ns;
            end
        end
    end

    assign state = state_q;

    // R8: a load strobe always wins the next cycle
    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> (state_q == ST_LOAD));

    // R6: a lone adjust strobe selects the shift state
    p_adjust_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_stb && !set_stb) |=> (state_q == ST_SHIFT));

    // R5: captured load operands match the strobed values
    p_load_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> (ld_sec == $past(set_sec)) && (ld_ns == $past(set_ns)));

endmodule

// File: rtl/tod_time_core.sv
module tod_time_core
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W  = 48,
    parameter int NS_W   = 30,
    parameter int STEP_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  steer_state_e      state,
    input  logic [SEC_W-1:0]  ld_sec,
    input  logic [NS_W-1:0]   ld_ns,
    input  logic              off_neg,
    input  logic [SEC_W-1:0]  off_sec,
    input  logic [NS_W-1:0]   off_ns,
    input  logic [STEP_W-1:0] step_ns,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns
);

    localparam int                     VW       = NS_W + 4;
    localparam logic signed [VW-1:0]   ONE_S    = VW'(NS_PER_SEC);
    localparam logic signed [VW-1:0]   TWO_S    = VW'(2 * NS_PER_SEC);
    localparam logic signed [VW-1:0]   NEG_ONE  = -ONE_S;
    localparam logic signed [VW-1:0]   NEG_TWO  = -TWO_S;
    localparam logic [NS_W-1:0]        NS_LIMIT = NS_W'(NS_PER_SEC);

    logic [SEC_W-1:0]        sec_q;
    logic [NS_W-1:0]         ns_q;
    logic signed [VW-1:0]    raw;
    logic signed [VW-1:0]    fix;
    logic [SEC_W-1:0]        base_sec;
    logic signed [2:0]       carry;
    logic [SEC_W-1:0]        sec_d;
    logic [NS_W-1:0]         ns_d;
    logic                    fix_unused;

    // Candidate value per steering state
    always_comb begin
        unique case (state)
            ST_LOAD: begin
                raw      = VW'(ld_ns);
                base_sec = ld_sec;
            end
            ST_SHIFT: begin
                raw      = VW'(ns_q) + VW'(step_ns)
                         + (off_neg ? -VW'(off_ns) : VW'(off_ns));
                base_sec = off_neg ? (sec_q - off_sec) : (sec_q + off_sec);
            end
            default: begin
                raw      = VW'(ns_q) + VW'(step_ns);
                base_sec = sec_q;
            end
        endcase
    end

    // Fold into one second, carrying or borrowing up to two
    always_comb begin
        if (raw < NEG_ONE) begin
            fix   = raw + TWO_S;
            carry = -3'sd2;
        end else if (raw < 0) begin
            fix   = raw + ONE_S;
            carry = -3'sd1;
        end else if (raw >= TWO_S) begin
            fix   = raw - TWO_S;
            carry = 3'sd2;
        end else if (raw >= ONE_S) begin
            fix   = raw - ONE_S;
            carry = 3'sd1;
        end else begin
            fix   = raw;
            carry = 3'sd0;
        end
        ns_d  = fix[NS_W-1:0];
        sec_d = base_sec + {{(SEC_W-3){carry[2]}}, carry};
    end

    assign fix_unused = ^fix[VW-1:NS_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ns_q  <= '0;
        end else begin
            sec_q <= sec_d;
            ns_q  <= ns_d;
        end
    end

    assign tod_sec = sec_q;
    assign tod_ns  = ns_q;

    // R4: nanoseconds stay below one second
    p_ns_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ns_q < NS_LIMIT);

    // R2: a plain tick adds the step, with at most one second of carry
    p_run_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=>
            ((ns_q == $past(ns_q) + NS_W'($past(step_ns))) && (sec_q == $past(sec_q)))
         || ((ns_q + NS_LIMIT == $past(ns_q) + NS_W'($past(step_ns)))
             && (sec_q == $past(sec_q) + SEC_W'(1))));

    // R5: an in-range load appears unchanged
    p_load_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LOAD) && (ld_ns < NS_LIMIT)) |=>
            (ns_q == $past(ld_ns)) && (sec_q == $past(ld_sec)));

endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W   = 48,
    parameter int NS_W    = 30,
    parameter int INC_W   = 6,
    parameter int FRAC_W  = 32,
    parameter int RST_INC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic [SEC_W-1:0]  set_sec,
    input  logic [NS_W-1:0]   set_ns,
    input  logic              adj_stb,
    input  logic              adj_neg,
    input  logic [SEC_W-1:0]  adj_sec,
    input  logic [NS_W-1:0]   adj_ns,
    input  logic              inc_stb,
    input  logic [INC_W-1:0]  inc_ns,
    input  logic [FRAC_W-1:0] inc_frac,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns
);

    localparam int STEP_W = INC_W + 1;

    steer_state_e      state;
    logic [SEC_W-1:0]  ld_sec;
    logic [NS_W-1:0]   ld_ns;
    logic              off_neg;
    logic [SEC_W-1:0]  off_sec;
    logic [NS_W-1:0]   off_ns;
    logic [STEP_W-1:0] step_ns;
    logic              restart;

    assign restart = (state == ST_LOAD);

    tod_steer_fsm #(
        .SEC_W (SEC_W),
        .NS_W  (NS_W)
    ) u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .set_sec (set_sec),
        .set_ns  (set_ns),
        .adj_stb (adj_stb),
        .adj_neg (adj_neg),
        .adj_sec (adj_sec),
        .adj_ns  (adj_ns),
        .state   (state),
        .ld_sec  (ld_sec),
        .ld_ns   (ld_ns),
        .off_neg (off_neg),
        .off_sec (off_sec),
        .off_ns  (off_ns)
    );

    tod_rate_accum #(
        .INC_W   (INC_W),
        .FRAC_W  (FRAC_W),
        .RST_INC (RST_INC)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_stb  (inc_stb),
        .inc_ns   (inc_ns),
        .inc_frac (inc_frac),
        .restart  (restart),
        .step_ns  (step_ns)
    );

    tod_time_core #(
        .SEC_W  (SEC_W),
        .NS_W   (NS_W),
        .STEP_W (STEP_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .ld_sec  (ld_sec),
        .ld_ns   (ld_ns),
        .off_neg (off_neg),
        .off_sec (off_sec),
        .off_ns  (off_ns),
        .step_ns (step_ns),
        .tod_sec (tod_sec),
        .tod_ns  (tod_ns)
    );

endmodule

// File: tb/test_ptp_tod_clock.sv
`timescale 1ns/1ps
module test_ptp_tod_clock;

    localparam longint NSPS = 64'd1_000_000_000;
    localparam longint FRAC_ONE = 64'h1_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_stb = 1'b0;
    logic [47:0] set_sec = '0;
    logic [29:0] set_ns = '0;
    logic        adj_stb = 1'b0;
    logic        adj_neg = 1'b0;
    logic [47:0] adj_sec = '0;
    logic [29:0] adj_ns = '0;
    logic        inc_stb = 1'b0;
    logic [5:0]  inc_ns = '0;
    logic [31:0] inc_frac = '0;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Scoreboard queues: cycle, expected total nanoseconds, requirement tag
    int     q_cyc[$];
    longint q_tot[$];
    string  q_tag[$];

    // Bench model of the clock
    longint m_tot = 0;
    longint m_frac = 0;
    longint m_inc_ns = 8;
    longint m_inc_frac = 0;
    int     m_cyc = 0;

    always #4 clk = ~clk;

    ptp_tod_clock i_ptp_tod_clock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (set_stb),
        .set_sec  (set_sec),
        .set_ns   (set_ns),
        .adj_stb  (adj_stb),
        .adj_neg  (adj_neg),
        .adj_sec  (adj_sec),
        .adj_ns   (adj_ns),
        .inc_stb  (inc_stb),
        .inc_ns   (inc_ns),
        .inc_frac (inc_frac),
        .tod_sec  (tod_sec),
        .tod_ns   (tod_ns)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic compare(input string tag, input int at, input longint tot);
        longint es;
        longint en;
        longint as_;
        longint an;
        es  = tot / NSPS;
        en  = tot % NSPS;
        as_ = longint'(tod_sec);
        an  = longint'(tod_ns);
        checks++;
        if (as_ != es || an != en) begin
            errors++;
            $display("FAIL %s cyc=%0d actual=%0d.%09d expected=%0d.%09d",
                     tag, at, as_, an, es, en);
        end
    endtask

    // Monitor: pops expected items as their cycle arrives
    always @(negedge clk) begin
        if (rst_n) begin
            while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
                int     c;
                longint t;
                string  g;
                c = q_cyc.pop_front();
                t = q_tot.pop_front();
                g = q_tag.pop_front();
                if (c != cyc) begin
                    checks++;
                    errors++;
                    $display("FAIL %s missed cycle: actual=%0d expected=%0d", g, cyc, c);
                end else begin
                    compare(g, c, t);
                end
            end
        end
    end

    function automatic void m_step();
        m_frac = m_frac + m_inc_frac;
        if (m_frac >= FRAC_ONE) begin
            m_frac = m_frac - FRAC_ONE;
            m_tot  = m_tot + m_inc_ns + 1;
        end else begin
            m_tot  = m_tot + m_inc_ns;
        end
        m_cyc++;
    endfunction

    function automatic void push(input string tag);
        q_cyc.push_back(m_cyc);
        q_tot.push_back(m_tot);
        q_tag.push_back(tag);
    endfunction

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            m_step();
            push(tag);
        end
        repeat (n) @(negedge clk);
    endtask

    // Drives one or both steering strobes for a single cycle
    task automatic steer(input bit do_set, input longint s, input longint ns,
                         input bit do_adj, input bit neg, input longint as_,
                         input longint ans, input string tag);
        set_stb = do_set;
        set_sec = 48'(s);
        set_ns  = 30'(ns);
        adj_stb = do_adj;
        adj_neg = neg;
        adj_sec = 48'(as_);
        adj_ns  = 30'(ans);
        m_step();
        push(tag);
        if (do_set) begin
            m_tot  = s * NSPS + ns;
            m_frac = 0;
            m_cyc++;
        end else begin
            m_step();
            if (neg) m_tot = m_tot - (as_ * NSPS + ans);
            else     m_tot = m_tot + (as_ * NSPS + ans);
        end
        push(tag);
        @(negedge clk);
        set_stb = 1'b0;
        adj_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_rate(input longint n, input longint f, input string tag);
        inc_stb  = 1'b1;
        inc_ns   = 6'(n);
        inc_frac = 32'(f);
        m_step();
        push(tag);
        m_inc_ns   = n;
        m_inc_frac = f;
        @(negedge clk);
        inc_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 in reset", 0, 0);
        rst_n = 1'b1;
        compare("R1 at release", 0, 0);

        run(6, "R1 R2 free run");

        steer(1, 5, 999_999_995, 0, 0, 0, 0, "R5 load");
        run(3, "R4 rollover");
        steer(1, 7, 1_000_000_005, 0, 0, 0, 0, "R5 oversize ns");
        run(1, "R5 resume");

        steer(1, 10, 500_000_000, 0, 0, 0, 0, "R5 load");
        steer(0, 0, 0, 1, 0, 1, 600_000_000, "R6 add carry");
        run(2, "R6 after");
        steer(1, 3, 999_999_000, 0, 0, 0, 0, "R5 load");
        steer(0, 0, 0, 1, 0, 0, 1_073_741_000, "R6 double carry");
        steer(0, 0, 0, 1, 0, 2, 5, "R6 small add");

        steer(1, 20, 100, 0, 0, 0, 0, "R5 load");
        steer(0, 0, 0, 1, 1, 1, 500, "R7 borrow");
        run(2, "R7 after");
        steer(1, 30, 10, 0, 0, 0, 0, "R5 load");
        steer(0, 0, 0, 1, 1, 0, 1_073_741_823, "R7 double borrow");
        steer(0, 0, 0, 1, 1, 3, 7, "R7 plain subtract");

        steer(1, 40, 250, 1, 0, 1, 5, "R8 both strobes");
        run(2, "R8 after");

        set_rate(8, 64'h8000_0000, "R9 old rate");
        run(1, "R9 new rate");
        steer(1, 50, 0, 0, 0, 0, 0, "R3 load clears fraction");
        run(8, "R3 half ns");
        set_rate(3, 64'h4000_0000, "R9 old rate");
        run(9, "R3 R9 quarter ns");
        steer(1, 60, 999_999_990, 0, 0, 0, 0, "R3 reload");
        run(8, "R3 R4 quarter ns rollover");
        set_rate(8, 0, "R9 restore");
        run(3, "R2 restored");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule